// File: doc/BRIEF.md
# Progressive-Group Carry-Select Adder

This block adds two unsigned operands of a configurable width together with a carry-in. It has no clock. It produces a sum of the same width and a carry-out. The operand bits are split into groups that begin at the least significant bit. The first two groups are one bit wide, and each group after them is one bit wider than the group before it. The most significant group is cut short so that the groups exactly cover the width.

The lowest group takes the external carry-in and adds with a plain ripple chain. Every higher group holds two ripple chains that run in parallel: one assumes its incoming carry is 0 and the other assumes it is 1. A chain of two-way selectors then passes the real carry upward. At each group boundary the real carry picks one of the two prepared results and does not ripple through the group. Because the groups widen step by step, the ripple time inside a group roughly matches the time the selector chain takes to reach that group. The group boundaries are computed from the width parameter when the design is elaborated.

Top module: `csel_adder`

## Requirements
- R1: For every a_i, b_i and cin_i, the concatenation {cout_o, sum_o} equals the unsigned sum a_i + b_i + cin_i, computed with one extra bit of width.
- R2: Starting from bit 0, the group lengths are 1, 1, 2, 3, 4, and so on. The last group is truncated to fit WIDTH. Results stay correct for widths whose last group is truncated (for example 5 and 8) and for widths whose groups fit exactly (for example 16).
- R3: Each group above the lowest one forms two candidate results by ripple addition, one for an incoming carry of 0 and one for an incoming carry of 1. The carry-1 candidate, read as {carry, sum}, is exactly one more than the carry-0 candidate.
- R4: With a_i all ones, b_i zero and cin_i = 1, sum_o is all zeros and cout_o is 1. The carry passes through every selector.
- R5: When every bit position propagates (a_i XOR b_i is all ones), cout_o equals cin_i. sum_o is then all ones when cin_i = 0 and all zeros when cin_i = 1.
- R6: With a_i and b_i both all ones, cout_o is 1 and sum_o is all ones except bit 0, where bit 0 equals cin_i.
- R7: With both operands zero, the outputs are {cout_o, sum_o} = {0, 0...0, cin_i}.
- R8: sum_o[0] depends only on a_i[0], b_i[0] and cin_i: it equals their XOR. The lowest group uses the external carry directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First addend |
| b_i | input | WIDTH | Second addend |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The 5-bit and 8-bit instances are swept over every operand pair with both carry-in values. This covers every carry pattern across a truncated last group and shows whether each selector picks the right candidate in every boundary case. The 16-bit instance, whose groups fit exactly, is tried with structured patterns: zeros, all ones, fully propagating operand pairs, and an all-ones operand added to a carry-in. Long carry paths through the selector chain show up here. Random operands with both carry values follow, and they catch errors in group slicing. Bit 0 and the candidate-pair relation are also watched continuously by the in-design assertions.

// File: rtl/csel_pkg.sv
package csel_pkg;

  // Nominal length of group k: 1, 1, 2, 3, 4, ...
  function automatic int grp_len(input int k);
    return (k == 0) ? 1 : k;
  endfunction

  // Bit index where group k begins
  function automatic int grp_lsb(input int k);
    return (k == 0) ? 0 : 1 + ((k - 1) * k) / 2;
  endfunction

  // Number of groups needed to cover w bits
  function automatic int grp_count(input int w);
    int n;
    n = 0;
    for (int k = 0; k < w; k++) begin
      if (grp_lsb(k) < w) n++;
    end
    return n;
  endfunction

  // Actual length of group k after truncation to w bits
  function automatic int grp_eff_len(input int k, input int w);
    int rem;
    rem = w - grp_lsb(k);
    return (grp_len(k) < rem) ? grp_len(k) : rem;
  endfunction

endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  always_comb begin
    logic c;
    c = cin_i;
    for (int i = 0; i < W; i++) begin
      sum_o[i] = a_i[i] ^ b_i[i] ^ c;
      c        = (a_i[i] & b_i[i]) | (c & (a_i[i] ^ b_i[i]));
    end
    cout_o = c;
  end

endmodule

// File: rtl/csel_group.sv
module csel_group #(
  parameter int W = 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum0_o,
  output logic [W-1:0] sum1_o,
  output logic         cout0_o,
  output logic         cout1_o
);

  csel_ripple #(.W(W)) chain0_i (
    .a_i(a_i), .b_i(b_i), .cin_i(1'b0), .sum_o(sum0_o), .cout_o(cout0_o)
  );

  csel_ripple #(.W(W)) chain1_i (
    .a_i(a_i), .b_i(b_i), .cin_i(1'b1), .sum_o(sum1_o), .cout_o(cout1_o)
  );

  // The two independent chains must stay exactly one apart
  always_comb begin
    assert_cand_offset_R3: assert ({cout1_o, sum1_o} == ({cout0_o, sum0_o} + 1'b1))
      else $error("R3: carry-1 candidate is not carry-0 candidate plus one");
    assert_carry_mono_R3: assert (!cout0_o || cout1_o)
      else $error("R3: carry-0 chain carries while carry-1 chain does not");
  end

endmodule

// File: rtl/csel_pick.sv
module csel_pick #(
  parameter int W = 2
) (
  input  logic         sel_i,
  input  logic [W-1:0] sum0_i,
  input  logic [W-1:0] sum1_i,
  input  logic         cout0_i,
  input  logic         cout1_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  assign sum_o  = sel_i ? sum1_i  : sum0_i;
  assign cout_o = sel_i ? cout1_i : cout0_i;

endmodule

// File: rtl/csel_adder.sv
module csel_adder
  import csel_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int NGRP = grp_count(WIDTH);

  // Real carry arriving at each group boundary
  logic [NGRP:0] grp_carry;
  assign grp_carry[0] = cin_i;

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    localparam int LSB = grp_lsb(k);
    localparam int LEN = grp_eff_len(k, WIDTH);

    if (k == 0) begin : g_first
      csel_ripple #(.W(LEN)) base_i (
        .a_i   (a_i[LSB +: LEN]),
        .b_i   (b_i[LSB +: LEN]),
        .cin_i (grp_carry[0]),
        .sum_o (sum_o[LSB +: LEN]),
        .cout_o(grp_carry[1])
      );
    end else begin : g_sel
      logic [LEN-1:0] cand_s0;
      logic [LEN-1:0] cand_s1;
      logic           cand_c0;
      logic           cand_c1;

      csel_group #(.W(LEN)) pair_i (
        .a_i    (a_i[LSB +: LEN]),
        .b_i    (b_i[LSB +: LEN]),
        .sum0_o (cand_s0),
        .sum1_o (cand_s1),
        .cout0_o(cand_c0),
        .cout1_o(cand_c1)
      );

      csel_pick #(.W(LEN)) pick_i (
        .sel_i  (grp_carry[k]),
        .sum0_i (cand_s0),
        .sum1_i (cand_s1),
        .cout0_i(cand_c0),
        .cout1_i(cand_c1),
        .sum_o  (sum_o[LSB +: LEN]),
        .cout_o (grp_carry[k+1])
      );
    end
  end

  assign cout_o = grp_carry[NGRP];

  always_comb begin
    assert_sum_match_R1: assert ({cout_o, sum_o} ==
        ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
      else $error("R1: adder output differs from arithmetic sum");
    assert_bit0_R8: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ cin_i))
      else $error("R8: bit 0 does not follow its own inputs");
    if (&(a_i ^ b_i)) begin
      assert_full_prop_R5: assert (cout_o == cin_i)
        else $error("R5: propagate-everywhere carry-out differs from carry-in");
    end
  end

endmodule

// File: tb/csel_adder_tb.sv
module csel_adder_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  // 16-bit instance
  logic [15:0] a16, b16, s16;
  logic        c16, co16;
  csel_adder #(.WIDTH(16)) dut_i (
    .a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16), .cout_o(co16)
  );

  // 8-bit instance (last group truncated)
  logic [7:0] a8, b8, s8;
  logic       c8, co8;
  csel_adder #(.WIDTH(8)) dut8_i (
    .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8), .cout_o(co8)
  );

  // 5-bit instance (last group truncated to one bit)
  logic [4:0] a5, b5, s5;
  logic       c5, co5;
  csel_adder #(.WIDTH(5)) dut5_i (
    .a_i(a5), .b_i(b5), .cin_i(c5), .sum_o(s5), .cout_o(co5)
  );

  task automatic compare(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run16(input string req, input logic [15:0] a, input logic [15:0] b,
                       input logic c);
    longint exp;
    @(negedge clk);
    a16 = a; b16 = b; c16 = c;
    #5;
    exp = longint'(a) + longint'(b) + longint'(c);
    compare(req, longint'({co16, s16}), exp);
  endtask

  initial begin
    a16 = '0; b16 = '0; c16 = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    a5 = '0; b5 = '0; c5 = 1'b0;

    // R7: idle inputs give zero outputs
    #5;
    compare("R7 zero in 16", longint'({co16, s16}), 0);
    compare("R7 zero in 8", longint'({co8, s8}), 0);
    run16("R7 zero with cin", 16'h0000, 16'h0000, 1'b1);

    // R4: carry runs through every selector
    run16("R4 all-ones plus cin", 16'hFFFF, 16'h0000, 1'b1);
    compare("R4 sum zero / cout one", longint'({co16, s16}), 64'h10000);

    // R5: every position propagates
    run16("R5 propagate cin0", 16'hA5C3, 16'h5A3C, 1'b0);
    compare("R5 cout equals cin 0", longint'(co16), 0);
    run16("R5 propagate cin1", 16'hF0F0, 16'h0F0F, 1'b1);
    compare("R5 cout equals cin 1", longint'(co16), 1);

    // R6: every position generates
    run16("R6 generate cin0", 16'hFFFF, 16'hFFFF, 1'b0);
    run16("R6 generate cin1", 16'hFFFF, 16'hFFFF, 1'b1);
    compare("R6 sum pattern", longint'(s16), 64'hFFFF);

    // R2/R3: carries that cross each group boundary (bits 1,2,4,7,11)
    for (int p = 0; p < 16; p++) begin
      run16("R2 boundary walk", 16'((32'h1 << p) - 1), 16'h0001, 1'b0);
      run16("R3 boundary walk cin", 16'((32'h1 << p) - 1), 16'h0000, 1'b1);
    end

    // R8: bit 0 on its own
    run16("R8 bit0 only", 16'h0001, 16'h0000, 1'b1);
    compare("R8 bit0 value", longint'(s16[0]), 0);

    // R1: random operands, both carry values
    for (int i = 0; i < 20000; i++) begin
      run16("R1 random 16", 16'($urandom), 16'($urandom), 1'($urandom));
    end

    // R2: exhaustive 8-bit sweep
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        for (int c = 0; c < 2; c++) begin
          @(negedge clk);
          a8 = 8'(a); b8 = 8'(b); c8 = 1'(c);
          #5;
          compare("R2 exhaustive 8", longint'({co8, s8}), longint'(a + b + c));
        end
      end
    end

    // R2: exhaustive 5-bit sweep
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        for (int c = 0; c < 2; c++) begin
          @(negedge clk);
          a5 = 5'(a); b5 = 5'(b); c5 = 1'(c);
          #5;
          compare("R2 exhaustive 5", longint'({co5, s5}), longint'(a + b + c));
        end
      end
    end

    done = 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 195000 && !done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    wait (done);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule